// File: doc/BRIEF.md
# Tag-Renaming Issue Stage with Result Broadcast

This block takes instructions in program order, one per cycle, and places each into a free waiting slot of the kind its operation needs. Arithmetic slots feed a short pipelined adder unit, and multiply slots feed a longer pipelined multiplier unit. When an instruction is accepted, each of its two source registers is replaced by something the slot can use. If no instruction is still going to write that register, the slot takes the register's value. If one is, the slot takes the small numeric tag of the slot that will produce the value. The destination register then records the new slot's tag as its pending writer.

Each finished result goes out on a single shared result bus together with the tag of the slot that produced it. Every slot that is waiting for that tag captures the value from the bus. Every register whose pending-writer tag still equals the broadcast tag also captures the value. Because of this, an instruction never has to wait for an older reader of its destination, and it never has to wait for an older writer of the same register.

Each slot runs a three-state controller. In Free, an allocation at issue moves the slot to Wait. In Wait, the slot is dispatched to its unit once both of its operand tags are zero, and it moves to Exec. In Exec, the slot returns to Free on the cycle its own tag appears on the bus. The register file holds architectural values, and a read port shows one register's value and whether a write to it is still pending.

Top module: `rs_bcast_core`

## Requirements
- R1: After reset, register i holds the value i+1, no register is pending, the bus is idle, `idle` is high and `iss_ready` is high for every operation.
- R2: Operation codes are 0 = add, 1 = subtract (src1 minus src2), 2 = multiply (low DATA_W bits of the product) and 3 = bitwise XOR. Once all issued work has drained, every register equals the result of executing the accepted instructions strictly one after another in issue order.
- R3: Tags are numbered from 1, and tag 0 means "no producer". Codes 0, 1 and 3 use the arithmetic slots, which carry tags 1 to N_ALU. Code 2 uses the multiply slots, which carry tags N_ALU+1 to N_ALU+N_MUL. The lowest-numbered free slot of the required kind is the one allocated.
- R4: `iss_ready` is low whenever every slot of the kind the presented operation needs is occupied. This does not depend on the occupancy of the other kind.
- R5: An accepted instruction makes its destination read as pending until a broadcast carries that instruction's own tag. An earlier producer of the same register that finishes later changes neither the register's value nor its pending flag.
- R6: A waiting instruction uses the value its source register had at its own issue, even if a later instruction overwrites that register first.
- R7: An instruction accepted in the same cycle that its source's producer is on the bus takes the bus value directly, and it still completes.
- R8: At most one result is on the bus per cycle. The multiplier unit has priority over the adder unit, and the loser holds its result until it wins. With no contention, an instruction whose operands are ready and that is accepted at edge t appears on the bus in the cycle after edge t+LAT, where LAT is that unit's latency.
- R9: A slot becomes free again when its own tag is broadcast, and `idle` rises once every slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented |
| iss_op | input | 2 | Operation code |
| iss_dst | input | RA_W | Destination register |
| iss_src1 | input | RA_W | First source register |
| iss_src2 | input | RA_W | Second source register |
| iss_ready | output | 1 | A slot of the required kind is free; the instruction is accepted at the edge when valid and ready are both high |
| rd_addr | input | RA_W | Register read address |
| rd_data | output | DATA_W | Architectural value of the addressed register |
| rd_pend | output | 1 | The addressed register has a pending writer |
| bus_valid | output | 1 | A result is being broadcast |
| bus_tag | output | 4 | Tag of the producing slot |
| bus_value | output | DATA_W | Broadcast result |
| idle | output | 1 | All slots are free |

## Verification
A wrong entry in the register status table or in a slot's operand tag shows up in one of two ways. It can leave a register pending forever, which the drain wait reports once its bounded timeout expires. Or it can deliver a value that differs from in-order execution, which the register comparison after each drain reports. Arbitration and latency faults appear on the bus within the few cycles that the latency requirement fixes, so the bench compares the bus tag on exact cycles. Write-after-write, write-after-read and same-cycle bypass faults each corrupt a specific register that a directed sequence reads back right after the relevant broadcast.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_XOR = 2'd3
    } rs_op_e;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2
    } stn_state_e;

    function automatic logic op_is_mul(input logic [1:0] op);
        return op == 2'(OP_MUL);
    endfunction

endpackage

// File: rtl/rs_station.sv
module rs_station #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    parameter int MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [1:0]        a_op,
    input  logic [DATA_W-1:0] a_vj,
    input  logic [TAG_W-1:0]  a_qj,
    input  logic [DATA_W-1:0] a_vk,
    input  logic [TAG_W-1:0]  a_qk,
    input  logic              disp,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output logic              busy,
    output logic              ready,
    output logic [1:0]        op,
    output logic [DATA_W-1:0] vj,
    output logic [DATA_W-1:0] vk
);
    import rs_pkg::*;

    localparam logic [TAG_W-1:0] SELF = TAG_W'(MY_TAG);

    stn_state_e state, state_nxt;
    logic [TAG_W-1:0] qj, qk;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FREE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FREE: if (alloc) state_nxt = ST_WAIT;
            ST_WAIT: if (disp)  state_nxt = ST_EXEC;
            ST_EXEC: if (bus_valid && bus_tag == SELF) state_nxt = ST_FREE;
            default: state_nxt = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op <= '0;
            vj <= '0;
            vk <= '0;
            qj <= '0;
            qk <= '0;
        end else if (alloc) begin
            op <= a_op;
            vj <= a_vj;
            vk <= a_vk;
            qj <= a_qj;
            qk <= a_qk;
        end else if (state == ST_WAIT && bus_valid) begin
            if (qj != '0 && qj == bus_tag) begin
                vj <= bus_value;
                qj <= '0;
            end
            if (qk != '0 && qk == bus_tag) begin
                vk <= bus_value;
                qk <= '0;
            end
        end
    end

    always_comb begin
        busy  = (state != ST_FREE);
        ready = (state == ST_WAIT) && (qj == '0) && (qk == '0);
    end

endmodule

// File: rtl/rs_exec_unit.sv
module rs_exec_unit #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    parameter int LAT    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              grant,
    output logic              accept,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_value
);
    import rs_pkg::*;

    logic [LAT-1:0]    sv;
    logic [TAG_W-1:0]  st [LAT];
    logic [DATA_W-1:0] sd [LAT];
    logic [DATA_W-1:0] res;
    logic [2*DATA_W-1:0] prod;

    always_comb begin
        prod = in_a * in_b;
        unique case (rs_op_e'(in_op))
            OP_ADD:  res = in_a + in_b;
            OP_SUB:  res = in_a - in_b;
            OP_MUL:  res = prod[DATA_W-1:0];
            OP_XOR:  res = in_a ^ in_b;
            default: res = '0;
        endcase
    end

    assign accept = !sv[LAT-1] || grant;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv[0] <= 1'b0;
            st[0] <= '0;
            sd[0] <= '0;
        end else if (accept) begin
            sv[0] <= in_valid;
            st[0] <= in_tag;
            sd[0] <= res;
        end
    end

    for (genvar k = 1; k < LAT; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sv[k] <= 1'b0;
                st[k] <= '0;
                sd[k] <= '0;
            end else if (accept) begin
                sv[k] <= sv[k-1];
                st[k] <= st[k-1];
                sd[k] <= sd[k-1];
            end
        end
    end

    assign out_valid = sv[LAT-1];
    assign out_tag   = st[LAT-1];
    assign out_value = sd[LAT-1];

endmodule

// File: rtl/rs_regstat.sv
module rs_regstat #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    parameter int NREG   = 8,
    parameter int RA_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             claim,
    input  logic [RA_W-1:0]                  claim_reg,
    input  logic [TAG_W-1:0]                 claim_tag,
    input  logic                             bus_valid,
    input  logic [TAG_W-1:0]                 bus_tag,
    input  logic [DATA_W-1:0]                bus_value,
    output logic [NREG-1:0][TAG_W-1:0]       stat,
    output logic [NREG-1:0][DATA_W-1:0]      regval
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic hit;
        assign hit = bus_valid && stat[r] != '0 && stat[r] == bus_tag;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regval[r] <= DATA_W'(r + 1);
                stat[r]   <= '0;
            end else begin
                if (hit) regval[r] <= bus_value;
                if (claim && claim_reg == RA_W'(r)) stat[r] <= claim_tag;
                else if (hit)                       stat[r] <= '0;
            end
        end
    end

endmodule

// File: rtl/rs_bcast_core.sv
module rs_bcast_core #(
    parameter int DATA_W  = 16,
    parameter int NREG    = 8,
    parameter int N_ALU   = 3,
    parameter int N_MUL   = 2,
    parameter int ALU_LAT = 1,
    parameter int MUL_LAT = 3,
    parameter int RA_W    = $clog2(NREG),
    localparam int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_op,
    input  logic [RA_W-1:0]   iss_dst,
    input  logic [RA_W-1:0]   iss_src1,
    input  logic [RA_W-1:0]   iss_src2,
    output logic              iss_ready,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_pend,
    output logic              bus_valid,
    output logic [TAG_W-1:0]  bus_tag,
    output logic [DATA_W-1:0] bus_value,
    output logic              idle
);
    import rs_pkg::*;

    localparam int NSTN = N_ALU + N_MUL;

    logic [NREG-1:0][TAG_W-1:0]  stat;
    logic [NREG-1:0][DATA_W-1:0] regval;

    logic [NSTN-1:0]   stn_busy, stn_ready, alloc_oh, disp;
    logic [1:0]        stn_op [NSTN];
    logic [DATA_W-1:0] stn_vj [NSTN];
    logic [DATA_W-1:0] stn_vk [NSTN];

    logic              issue_fire, want_mul;
    logic [TAG_W-1:0]  alloc_tag;
    logic [TAG_W-1:0]  s1_raw, s2_raw, s1_q, s2_q;
    logic [DATA_W-1:0] s1_v, s2_v;

    logic              alu_go, alu_acc, alu_grant, alu_ov;
    logic              mul_go, mul_acc, mul_grant, mul_ov;
    logic [1:0]        alu_op, mul_op;
    logic [DATA_W-1:0] alu_a, alu_b, mul_a, mul_b, alu_oval, mul_oval;
    logic [TAG_W-1:0]  alu_tag, mul_tag, alu_otag, mul_otag;

    // source rename with same-cycle bus bypass
    always_comb begin
        s1_raw = stat[iss_src1];
        s2_raw = stat[iss_src2];
        if (s1_raw != '0 && bus_valid && bus_tag == s1_raw) begin
            s1_v = bus_value;  s1_q = '0;
        end else if (s1_raw != '0) begin
            s1_v = '0;         s1_q = s1_raw;
        end else begin
            s1_v = regval[iss_src1]; s1_q = '0;
        end
        if (s2_raw != '0 && bus_valid && bus_tag == s2_raw) begin
            s2_v = bus_value;  s2_q = '0;
        end else if (s2_raw != '0) begin
            s2_v = '0;         s2_q = s2_raw;
        end else begin
            s2_v = regval[iss_src2]; s2_q = '0;
        end
    end

    // lowest free slot of the required kind
    always_comb begin
        want_mul  = op_is_mul(iss_op);
        alloc_oh  = '0;
        alloc_tag = '0;
        iss_ready = 1'b0;
        for (int i = 0; i < NSTN; i++) begin
            if (!iss_ready && !stn_busy[i] && ((i >= N_ALU) == want_mul)) begin
                alloc_oh[i] = 1'b1;
                alloc_tag   = TAG_W'(i + 1);
                iss_ready   = 1'b1;
            end
        end
        issue_fire = iss_valid && iss_ready;
    end

    // dispatch: lowest ready slot per unit
    always_comb begin
        disp   = '0;
        alu_go = 1'b0; alu_op = '0; alu_a = '0; alu_b = '0; alu_tag = '0;
        mul_go = 1'b0; mul_op = '0; mul_a = '0; mul_b = '0; mul_tag = '0;
        for (int i = 0; i < NSTN; i++) begin
            if (i < N_ALU) begin
                if (stn_ready[i] && !alu_go && alu_acc) begin
                    disp[i] = 1'b1; alu_go = 1'b1; alu_op = stn_op[i];
                    alu_a = stn_vj[i]; alu_b = stn_vk[i]; alu_tag = TAG_W'(i + 1);
                end
            end else begin
                if (stn_ready[i] && !mul_go && mul_acc) begin
                    disp[i] = 1'b1; mul_go = 1'b1; mul_op = stn_op[i];
                    mul_a = stn_vj[i]; mul_b = stn_vk[i]; mul_tag = TAG_W'(i + 1);
                end
            end
        end
    end

    for (genvar i = 0; i < NSTN; i++) begin : g_stn
        rs_station #(.DATA_W(DATA_W), .TAG_W(TAG_W), .MY_TAG(i + 1)) u_stn (
            .clk(clk), .rst_n(rst_n),
            .alloc(issue_fire && alloc_oh[i]),
            .a_op(iss_op), .a_vj(s1_v), .a_qj(s1_q), .a_vk(s2_v), .a_qk(s2_q),
            .disp(disp[i]),
            .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
            .busy(stn_busy[i]), .ready(stn_ready[i]),
            .op(stn_op[i]), .vj(stn_vj[i]), .vk(stn_vk[i])
        );
    end

    rs_exec_unit #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LAT(ALU_LAT)) u_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(alu_go), .in_op(alu_op),
        .in_a(alu_a), .in_b(alu_b), .in_tag(alu_tag), .grant(alu_grant),
        .accept(alu_acc), .out_valid(alu_ov), .out_tag(alu_otag), .out_value(alu_oval)
    );

    rs_exec_unit #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LAT(MUL_LAT)) u_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(mul_go), .in_op(mul_op),
        .in_a(mul_a), .in_b(mul_b), .in_tag(mul_tag), .grant(mul_grant),
        .accept(mul_acc), .out_valid(mul_ov), .out_tag(mul_otag), .out_value(mul_oval)
    );

    // fixed priority: multiplier first
    always_comb begin
        mul_grant = mul_ov;
        alu_grant = alu_ov && !mul_ov;
        bus_valid = mul_ov || alu_ov;
        bus_tag   = mul_ov ? mul_otag : (alu_ov ? alu_otag : '0);
        bus_value = mul_ov ? mul_oval : (alu_ov ? alu_oval : '0);
    end

    rs_regstat #(.DATA_W(DATA_W), .TAG_W(TAG_W), .NREG(NREG), .RA_W(RA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .claim(issue_fire), .claim_reg(iss_dst), .claim_tag(alloc_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .stat(stat), .regval(regval)
    );

    assign rd_data = regval[rd_addr];
    assign rd_pend = |stat[rd_addr];
    assign idle    = ~|stn_busy;

endmodule

// File: rtl/rs_bcast_core_chk.sv
module rs_bcast_core_chk #(
    parameter int NREG  = 8,
    parameter int NSTN  = 5,
    parameter int TAG_W = 4,
    parameter int RA_W  = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       iss_valid,
    input logic                       iss_ready,
    input logic [RA_W-1:0]            iss_dst,
    input logic [TAG_W-1:0]           alloc_tag,
    input logic [NREG-1:0][TAG_W-1:0] stat,
    input logic [NSTN-1:0]            stn_busy,
    input logic                       bus_valid,
    input logic [TAG_W-1:0]           bus_tag,
    input logic                       alu_ov,
    input logic [TAG_W-1:0]           alu_otag,
    input logic                       mul_ov
);
    logic [(1<<TAG_W)-1:0] busy_ext;
    assign busy_ext = {{((1<<TAG_W)-NSTN-1){1'b0}}, stn_busy, 1'b0};

    // R3
    bus_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tag != '0) && (int'(bus_tag) <= NSTN));

    // R9
    producer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> busy_ext[bus_tag]);

    // R9
    slot_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> !busy_ext[$past(bus_tag)]);

    // R5
    dest_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> stat[$past(iss_dst)] == $past(alloc_tag));

    // R8
    loser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_ov && mul_ov) |=> alu_ov && $stable(alu_otag));

endmodule

bind rs_bcast_core rs_bcast_core_chk #(
    .NREG(NREG), .NSTN(NSTN), .TAG_W(TAG_W), .RA_W(RA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_dst(iss_dst), .alloc_tag(alloc_tag), .stat(stat), .stn_busy(stn_busy),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .alu_ov(alu_ov),
    .alu_otag(alu_otag), .mul_ov(mul_ov)
);

// File: tb/rs_bcast_core_bench.sv
`timescale 1ns/1ps
module rs_bcast_core_bench;

    localparam int DW = 16;
    localparam int NR = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [1:0]    iss_op = 2'd0;
    logic [2:0]    iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic          iss_ready;
    logic [2:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          rd_pend;
    logic          bus_valid;
    logic [3:0]    bus_tag;
    logic [DW-1:0] bus_value;
    logic          idle;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [DW-1:0] mdl [NR];

    rs_bcast_core u_rs_bcast_core (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_ready(iss_ready), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_pend(rd_pend), .bus_valid(bus_valid), .bus_tag(bus_tag),
        .bus_value(bus_value), .idle(idle)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [DW-1:0] calc(input logic [1:0] op, input logic [DW-1:0] a,
                                           input logic [DW-1:0] b);
        logic [2*DW-1:0] p;
        p = a * b;
        case (op)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return p[DW-1:0];
            default: return a ^ b;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int d, input int s1, input int s2);
        iss_valid = 1'b1; iss_op = op;
        iss_dst = 3'(d); iss_src1 = 3'(s1); iss_src2 = 3'(s2);
        #0.2;
        while (!iss_ready) begin
            @(posedge clk); #1;
        end
        mdl[d] = calc(op, mdl[s1], mdl[s2]);
        @(posedge clk); #1;
        iss_valid = 1'b0;
    endtask

    task automatic rdreg(input int r, output logic [DW-1:0] v, output logic p);
        rd_addr = 3'(r);
        #0.2;
        v = rd_data;
        p = rd_pend;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (!idle && n < 500) begin
            @(posedge clk); #1; n++;
        end
        chk(idle, req, "drain to idle", idle, 1);
        @(posedge clk); #1;
    endtask

    task automatic cmp_all(input string req);
        logic [DW-1:0] v;
        logic p;
        for (int r = 0; r < NR; r++) begin
            rdreg(r, v, p);
            chk(v == mdl[r] && !p, req, $sformatf("reg %0d value", r), v, mdl[r]);
        end
    endtask

    initial begin
        logic [DW-1:0] v;
        logic p;
        void'($urandom(32'h5EED_0042));
        for (int r = 0; r < NR; r++) mdl[r] = DW'(r + 1);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        for (int r = 0; r < NR; r++) begin
            rdreg(r, v, p);
            chk(v == DW'(r + 1) && !p, "R1", "reset reg", v, r + 1);
        end
        chk(idle && !bus_valid, "R1", "idle and bus quiet", {idle, bus_valid}, 2);
        iss_op = 2'd2; #0.2;
        chk(iss_ready, "R1", "ready for multiply", iss_ready, 1);
        iss_op = 2'd0; #0.2;
        chk(iss_ready, "R1", "ready for add", iss_ready, 1);

        // R8 / R3: multiply and add finish together, multiply wins
        issue(2'd2, 5, 2, 3);
        @(posedge clk); #1;
        issue(2'd0, 6, 0, 1);
        @(posedge clk); #1;
        chk(bus_valid && bus_tag == 4, "R8", "winner tag (mul slot 4)", bus_tag, 4);
        chk(bus_value == mdl[5], "R8", "winner value", bus_value, mdl[5]);
        @(posedge clk); #1;
        chk(bus_valid && bus_tag == 1, "R3", "held adder tag 1", bus_tag, 1);
        chk(bus_value == mdl[6], "R8", "held adder value", bus_value, mdl[6]);
        drain("R9");
        cmp_all("R2");

        // R4 multiply slots full, adder slots free
        issue(2'd2, 1, 2, 2);
        issue(2'd2, 3, 4, 4);
        iss_op = 2'd2; #0.2;
        chk(!iss_ready, "R4", "mul stall", iss_ready, 0);
        iss_op = 2'd0; #0.2;
        chk(iss_ready, "R4", "add unaffected", iss_ready, 1);
        drain("R9");
        cmp_all("R2");

        // R5 write-after-write: slow older writer, fast younger writer
        issue(2'd2, 1, 2, 3);
        rdreg(1, v, p);
        chk(p, "R5", "pending after issue", p, 1);
        issue(2'd0, 1, 4, 5);
        @(posedge clk); #1;
        @(posedge clk); #1;
        rdreg(1, v, p);
        chk(v == mdl[1] && !p, "R5", "younger result landed", v, mdl[1]);
        drain("R9");
        rdreg(1, v, p);
        chk(v == mdl[1] && !p, "R5", "older result ignored", v, mdl[1]);

        // R6 write-after-read
        issue(2'd2, 4, 2, 2);
        issue(2'd0, 5, 4, 3);
        issue(2'd1, 3, 1, 7);
        drain("R9");
        cmp_all("R6");

        // R7 issue in the broadcast cycle of the producer
        issue(2'd0, 2, 1, 6);
        @(posedge clk); #1;
        chk(bus_valid && bus_tag == 1, "R7", "producer on bus", bus_tag, 1);
        issue(2'd3, 7, 2, 2);
        issue(2'd0, 0, 7, 2);
        drain("R7");
        cmp_all("R7");

        // R2 random streams
        for (int round = 0; round < 4; round++) begin
            for (int n = 0; n < 60; n++) begin
                issue(2'($urandom % 4), int'($urandom % NR), int'($urandom % NR),
                      int'($urandom % NR));
                if (($urandom % 4) == 0) begin
                    repeat (int'($urandom % 3)) @(posedge clk);
                    #0;
                end
            end
            drain("R9");
            cmp_all("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule